// File: doc/BRIEF.md
# Fast Ethernet Receive Line Decoder

This block sits after clock recovery and slicing on a 100 Mb/s twisted-pair or fiber link. Each cycle it may take one recovered line symbol. On copper it reverses the line coding in stages. A three-level line symbol becomes an NRZI level. The NRZI transitions become NRZ bits. The NRZ bits are descrambled with an 11-bit key generator, whose sequence repeats every 2047 bits. The block then finds the 5-bit code-group boundary and turns each 5-bit group into a 4-bit nibble for the MAC side. On fiber, the line symbol already carries the NRZI level, and the descrambler is bypassed.

The symbol input is a valid-only stream. A line cannot be stalled, so there is no ready signal. A symbol is taken in every cycle in which `sym_valid` is high, and idle cycles in between are allowed. The nibble output is also valid-only. The consumer must accept each `nib_valid` pulse in the cycle it appears. At most one nibble is produced for every five accepted symbols. Lock is gained from the idle stream, so the block needs no configuration beyond the mode pin.

Top module: `fe_rx_decoder`

## Requirements
- R1: While reset is active, and after it until symbols arrive, `locked`, `rx_dv`, `nib_valid` and `nib_err` are 0 in copper mode.
- R2: In copper mode, `sym` uses the codes 2'b00 = zero, 2'b01 = positive and 2'b11 = negative. A symbol that differs from the previous accepted symbol yields an NRZ 1, and an unchanged symbol yields a 0. Cycles with `sym_valid` low are skipped without effect.
- R3: With `fiber_mode` high, `sym[0]` is the NRZI level. A level change is an NRZ 1. Descrambling is bypassed, and `locked` reads 1.
- R4: In copper mode, the key register is loaded from the inverted line bits. `locked` rises once LOCK_RUN consecutive bits (default 32) match the key recurrence k[n] = k[n-11] xor k[n-9]. Lock is gained again the same way after it is lost.
- R5: Once locked, `locked` falls when TMO_BITS descrambled bits (default 2048) go by without a run of at least IDLE_MIN (default 10) consecutive descrambled ones.
- R6: Alignment starts when the descrambled bits 11000 then 10001 arrive while locked. At that point `rx_dv` rises. Each following 5-bit group is taken with its first received bit as the group's MSB.
- R7: Each group is mapped 0..F from 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101. Each mapped group gives one single-cycle `nib_valid` pulse with `nib_data`.
- R8: The group 01101 ends the frame. `rx_dv` falls, and neither it nor the group 00111 that follows produces a nibble.
- R9: Any other group inside a frame produces a nibble with `nib_err` high and `nib_data` 0, and the frame continues.
- R10: The group 11111 inside a frame produces an error nibble (`nib_err` 1, `nib_data` 0) and ends the frame.
- R11: While `locked` is low, no nibble is produced, even for a well-formed frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fiber_mode | input | 1 | 1 selects fiber NRZI input and bypasses descrambling |
| sym_valid | input | 1 | A line symbol is present this cycle |
| sym | input | 2 | Line symbol (copper three-level code, or NRZI level in bit 0) |
| nib_valid | output | 1 | One decoded nibble this cycle |
| nib_data | output | 4 | Decoded nibble, 0 when in error |
| nib_err | output | 1 | Nibble came from an invalid or idle group inside a frame |
| rx_dv | output | 1 | Receiver is inside a frame |
| locked | output | 1 | Descrambler is locked (always 1 in fiber mode) |

## Verification
The assertions assume that the line symbols came from a correct transmit chain. That means only the three legal copper codes are used, and the scrambler key follows the same 11-bit recurrence. They also assume that `fiber_mode` changes only while reset is held. The bench keeps to these assumptions. It builds every symbol from its own scrambler and three-level encoder, which follow the rules in R2 and R4. It switches modes only around a reset, and it inserts symbol gaps only as whole idle cycles. Under these conditions, lock can only rise or fall on an accepted bit. Nibbles always come at least five bits apart, and a frame can only open while the descrambler is locked.

// File: rtl/fe_rx_pkg.sv
package fe_rx_pkg;

  localparam logic [9:0] GRP_START = 10'b11000_10001;
  localparam logic [4:0] GRP_END   = 5'b01101;
  localparam logic [4:0] GRP_IDLE  = 5'b11111;

  typedef struct packed {
    logic       ok;
    logic [3:0] nib;
  } grp_dec_t;

  function automatic grp_dec_t decode_grp(input logic [4:0] g);
    grp_dec_t r;
    r.ok  = 1'b1;
    r.nib = 4'h0;
    case (g)
      5'b11110: r.nib = 4'h0;
      5'b01001: r.nib = 4'h1;
      5'b10100: r.nib = 4'h2;
      5'b10101: r.nib = 4'h3;
      5'b01010: r.nib = 4'h4;
      5'b01011: r.nib = 4'h5;
      5'b01110: r.nib = 4'h6;
      5'b01111: r.nib = 4'h7;
      5'b10010: r.nib = 4'h8;
      5'b10011: r.nib = 4'h9;
      5'b10110: r.nib = 4'hA;
      5'b10111: r.nib = 4'hB;
      5'b11010: r.nib = 4'hC;
      5'b11011: r.nib = 4'hD;
      5'b11100: r.nib = 4'hE;
      5'b11101: r.nib = 4'hF;
      default:  r.ok  = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/fe_line_conv.sv
module fe_line_conv (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fiber_mode,
  input  logic       sym_valid,
  input  logic [1:0] sym,
  output logic       bit_valid,
  output logic       bit_out
);

  logic [1:0] prev_sym;
  logic       nrzi_lvl;
  logic       nrzi_next;

  // three-level step -> NRZI toggle; fiber supplies the NRZI level itself
  always_comb begin
    if (fiber_mode) nrzi_next = sym[0];
    else            nrzi_next = nrzi_lvl ^ (sym != prev_sym);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_sym  <= 2'b00;
      nrzi_lvl  <= 1'b0;
      bit_valid <= 1'b0;
      bit_out   <= 1'b0;
    end else begin
      bit_valid <= sym_valid;
      if (sym_valid) begin
        prev_sym <= sym;
        nrzi_lvl <= nrzi_next;
        bit_out  <= nrzi_next ^ nrzi_lvl;
      end
    end
  end

endmodule

// File: rtl/fe_descrambler.sv
module fe_descrambler #(
  parameter int LOCK_RUN = 32,
  parameter int IDLE_MIN = 10,
  parameter int TMO_BITS = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fiber_mode,
  input  logic bit_valid,
  input  logic bit_in,
  output logic d_valid,
  output logic d_out,
  output logic locked
);

  localparam int KEY_LEN = 11;
  localparam int RUN_W   = $clog2(LOCK_RUN);
  localparam int ONES_W  = $clog2(IDLE_MIN + 1);
  localparam int TMO_W   = $clog2(TMO_BITS);
  localparam logic [RUN_W-1:0]  RUN_LAST = RUN_W'(LOCK_RUN - 1);
  localparam logic [ONES_W-1:0] ONES_TOP = ONES_W'(IDLE_MIN);
  localparam logic [ONES_W-1:0] ONES_HIT = ONES_W'(IDLE_MIN - 1);
  localparam logic [TMO_W-1:0]  TMO_LAST = TMO_W'(TMO_BITS - 1);

  logic [KEY_LEN-1:0] key_sr;
  logic [RUN_W-1:0]   run_cnt;
  logic [ONES_W-1:0]  ones_cnt;
  logic [TMO_W-1:0]   tmo_cnt;
  logic               lock_q;
  logic               key_pred;
  logic               plain;
  logic               idle_seen;

  assign key_pred  = key_sr[KEY_LEN-1] ^ key_sr[KEY_LEN-3];
  assign plain     = bit_in ^ key_pred;
  assign idle_seen = plain && (ones_cnt >= ONES_HIT);
  assign locked    = lock_q | fiber_mode;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_sr   <= '0;
      run_cnt  <= '0;
      ones_cnt <= '0;
      tmo_cnt  <= '0;
      lock_q   <= 1'b0;
      d_valid  <= 1'b0;
      d_out    <= 1'b0;
    end else begin
      d_valid <= 1'b0;
      if (fiber_mode) begin
        lock_q  <= 1'b0;
        run_cnt <= '0;
        if (bit_valid) begin
          d_valid <= 1'b1;
          d_out   <= bit_in;
        end
      end else if (bit_valid) begin
        if (!lock_q) begin
          // acquisition: idle is all ones, so the key is the inverted line bit
          key_sr <= {key_sr[KEY_LEN-2:0], ~bit_in};
          if (key_pred == ~bit_in) begin
            if (run_cnt == RUN_LAST) begin
              lock_q   <= 1'b1;
              run_cnt  <= '0;
              ones_cnt <= '0;
              tmo_cnt  <= '0;
            end else begin
              run_cnt <= run_cnt + 1'b1;
            end
          end else begin
            run_cnt <= '0;
          end
        end else begin
          key_sr  <= {key_sr[KEY_LEN-2:0], key_pred};
          d_valid <= 1'b1;
          d_out   <= plain;
          if (!plain)                   ones_cnt <= '0;
          else if (ones_cnt != ONES_TOP) ones_cnt <= ones_cnt + 1'b1;
          if (idle_seen) begin
            tmo_cnt <= '0;
          end else if (tmo_cnt == TMO_LAST) begin
            lock_q  <= 1'b0;
            run_cnt <= '0;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
      end
    end
  end

  // R4
  lock_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(bit_valid) && !$past(fiber_mode)));

  // R5
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lock_q) && !$past(fiber_mode)) |-> $past(bit_valid));

endmodule

// File: rtl/fe_group_align.sv
module fe_group_align
  import fe_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       locked,
  input  logic       d_valid,
  input  logic       d_in,
  output logic       nib_valid,
  output logic [3:0] nib_data,
  output logic       nib_err,
  output logic       rx_dv
);

  localparam int GRP_BITS = 5;
  localparam int WIN_BITS = 2 * GRP_BITS;
  localparam int CNT_W    = $clog2(GRP_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GRP_BITS - 1);

  logic [WIN_BITS-1:0] win;
  logic [WIN_BITS-1:0] win_n;
  logic [CNT_W-1:0]    bit_cnt;
  logic                in_frame;
  logic [GRP_BITS-1:0] grp;
  grp_dec_t            dec;

  assign win_n = {win[WIN_BITS-2:0], d_in};
  assign grp   = win_n[GRP_BITS-1:0];
  assign dec   = decode_grp(grp);
  assign rx_dv = in_frame;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win       <= '0;
      bit_cnt   <= '0;
      in_frame  <= 1'b0;
      nib_valid <= 1'b0;
      nib_data  <= 4'h0;
      nib_err   <= 1'b0;
    end else begin
      nib_valid <= 1'b0;
      nib_err   <= 1'b0;
      if (d_valid) win <= win_n;
      if (!locked) begin
        in_frame <= 1'b0;
      end else if (d_valid) begin
        if (!in_frame) begin
          if (win_n == GRP_START) begin
            in_frame <= 1'b1;
            bit_cnt  <= '0;
          end
        end else if (bit_cnt != CNT_LAST) begin
          bit_cnt <= bit_cnt + 1'b1;
        end else begin
          bit_cnt <= '0;
          if (grp == GRP_END) begin
            in_frame <= 1'b0;
          end else if (grp == GRP_IDLE) begin
            in_frame  <= 1'b0;
            nib_valid <= 1'b1;
            nib_err   <= 1'b1;
            nib_data  <= 4'h0;
          end else begin
            nib_valid <= 1'b1;
            nib_err   <= ~dec.ok;
            nib_data  <= dec.ok ? dec.nib : 4'h0;
          end
        end
      end
    end
  end

  // R6
  frame_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> ($past(locked) && $past(d_valid)));

  // R7
  nib_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_valid |=> !nib_valid);

  // R11
  nib_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nib_valid |-> $past(locked));

endmodule

// File: rtl/fe_rx_decoder.sv
module fe_rx_decoder #(
  parameter int LOCK_RUN = 32,
  parameter int IDLE_MIN = 10,
  parameter int TMO_BITS = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fiber_mode,
  input  logic       sym_valid,
  input  logic [1:0] sym,
  output logic       nib_valid,
  output logic [3:0] nib_data,
  output logic       nib_err,
  output logic       rx_dv,
  output logic       locked
);

  logic nrz_valid;
  logic nrz_bit;
  logic pl_valid;
  logic pl_bit;

  fe_line_conv u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .fiber_mode (fiber_mode),
    .sym_valid  (sym_valid),
    .sym        (sym),
    .bit_valid  (nrz_valid),
    .bit_out    (nrz_bit)
  );

  fe_descrambler #(
    .LOCK_RUN (LOCK_RUN),
    .IDLE_MIN (IDLE_MIN),
    .TMO_BITS (TMO_BITS)
  ) u_descr (
    .clk        (clk),
    .rst_n      (rst_n),
    .fiber_mode (fiber_mode),
    .bit_valid  (nrz_valid),
    .bit_in     (nrz_bit),
    .d_valid    (pl_valid),
    .d_out      (pl_bit),
    .locked     (locked)
  );

  fe_group_align u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .locked    (locked),
    .d_valid   (pl_valid),
    .d_in      (pl_bit),
    .nib_valid (nib_valid),
    .nib_data  (nib_data),
    .nib_err   (nib_err),
    .rx_dv     (rx_dv)
  );

endmodule

// File: tb/fe_rx_decoder_bench.sv
module fe_rx_decoder_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fiber_mode = 1'b0;
  logic       sym_valid = 1'b0;
  logic [1:0] sym = 2'b00;
  logic       nib_valid;
  logic [3:0] nib_data;
  logic       nib_err;
  logic       rx_dv;
  logic       locked;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [10:0] kq = 11'h2C5;
  logic        lvl = 1'b0;
  int          mstep = 0;
  logic [4:0]  exp_q[$];
  logic [4:0]  got_q[$];

  always #10 clk = ~clk;

  fe_rx_decoder u_fe_rx_decoder (
    .clk(clk), .rst_n(rst_n), .fiber_mode(fiber_mode),
    .sym_valid(sym_valid), .sym(sym),
    .nib_valid(nib_valid), .nib_data(nib_data), .nib_err(nib_err),
    .rx_dv(rx_dv), .locked(locked)
  );

  always @(negedge clk) if (rst_n && nib_valid) got_q.push_back({nib_err, nib_data});

  function automatic logic [4:0] enc(input logic [3:0] n);
    logic [4:0] t[16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                          5'b01010, 5'b01011, 5'b01110, 5'b01111,
                          5'b10010, 5'b10011, 5'b10110, 5'b10111,
                          5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    n_tests++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic drive_bit(input logic p, input bit gap);
    logic k, s;
    if (!fiber_mode) begin
      k = kq[10] ^ kq[8];
      kq = {kq[9:0], k};
      s = p ^ k;
    end else s = p;
    if (s) begin
      lvl = ~lvl;
      mstep = (mstep + 1) % 4;
    end
    if (fiber_mode) sym = {1'b0, lvl};
    else sym = (mstep == 1) ? 2'b01 : (mstep == 3) ? 2'b11 : 2'b00;
    sym_valid = 1'b1;
    @(negedge clk);
    if (gap) begin
      sym_valid = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic send_grp(input logic [4:0] g, input bit gap = 0);
    for (int i = 4; i >= 0; i--) drive_bit(g[i], gap);
  endtask

  task automatic send_idle(input int n);
    for (int i = 0; i < n; i++) send_grp(5'b11111);
  endtask

  task automatic send_nib(input logic [3:0] n, input bit gap = 0);
    send_grp(enc(n), gap);
    exp_q.push_back({1'b0, n});
  endtask

  task automatic send_end();
    send_grp(5'b01101);
    send_grp(5'b00111);
  endtask

  task automatic flush(input int n);
    sym_valid = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic cmp_stream(input string req);
    flush(6);
    chk({req, " nibble count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      chk({req, " nibble {err,data}"}, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic do_reset(input logic fx);
    sym_valid = 1'b0;
    rst_n = 1'b0;
    fiber_mode = fx;
    lvl = 1'b0;
    mstep = 0;
    sym = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    repeat (3) @(negedge clk);
    chk("R1 locked", locked, 0);
    chk("R1 rx_dv", rx_dv, 0);
    chk("R1 nib_valid", nib_valid, 0);
    chk("R1 nib_err", nib_err, 0);
  endtask

  task automatic t_lock();
    send_idle(4);
    flush(3);
    chk("R4 not yet locked after 20 bits", locked, 0);
    send_idle(16);
    flush(3);
    chk("R4 locked after idle run", locked, 1);
  endtask

  task automatic t_frame();
    send_grp(5'b11000);
    send_grp(5'b10001);
    send_nib(4'h5);
    send_nib(4'hD);
    flush(4);
    chk("R6 rx_dv inside frame", rx_dv, 1);
    for (int n = 0; n < 16; n++) send_nib(4'(n));
    send_end();
    send_idle(4);
    flush(4);
    chk("R8 rx_dv after end group", rx_dv, 0);
    cmp_stream("R7 R2 R8 frame over three-level line");
  endtask

  task automatic t_gaps();
    send_grp(5'b11000, 1);
    send_grp(5'b10001, 1);
    send_nib(4'h9, 1);
    send_nib(4'h6, 1);
    send_nib(4'h3, 1);
    send_end();
    send_idle(4);
    cmp_stream("R2 frame with symbol gaps");
  endtask

  task automatic t_invalid();
    send_grp(5'b11000);
    send_grp(5'b10001);
    send_nib(4'h1);
    send_grp(5'b00000);
    exp_q.push_back(5'b1_0000);
    send_grp(5'b00100);
    exp_q.push_back(5'b1_0000);
    send_nib(4'h2);
    flush(4);
    chk("R9 frame continues after bad group", rx_dv, 1);
    send_end();
    send_idle(4);
    cmp_stream("R9 bad groups in frame");
  endtask

  task automatic t_idle_end();
    send_grp(5'b11000);
    send_grp(5'b10001);
    send_nib(4'h3);
    send_idle(3);
    exp_q.push_back(5'b1_0000);
    flush(4);
    chk("R10 rx_dv after idle in frame", rx_dv, 0);
    cmp_stream("R10 idle ends frame");
    send_idle(4);
  endtask

  task automatic t_loss();
    for (int i = 0; i < 300; i++) send_grp(5'b00000);
    flush(3);
    chk("R5 still locked before timeout", locked, 1);
    for (int i = 0; i < 130; i++) send_grp(5'b00000);
    flush(3);
    chk("R5 lock lost after timeout", locked, 0);
    send_grp(5'b11000);
    send_grp(5'b10001);
    send_grp(enc(4'h1));
    send_grp(enc(4'h2));
    send_end();
    cmp_stream("R11 frame while unlocked");
    chk("R11 rx_dv while unlocked", rx_dv, 0);
    send_idle(20);
    flush(3);
    chk("R4 relock after loss", locked, 1);
  endtask

  task automatic t_fiber();
    do_reset(1'b1);
    chk("R3 fiber locked", locked, 1);
    send_idle(4);
    send_grp(5'b11000);
    send_grp(5'b10001);
    send_nib(4'h7);
    send_nib(4'hC);
    send_nib(4'h0);
    send_end();
    send_idle(3);
    cmp_stream("R3 fiber frame");
    chk("R3 fiber rx_dv after end", rx_dv, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_lock();
    t_frame();
    t_gaps();
    t_invalid();
    t_idle_end();
    t_loss();
    t_fiber();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule